// File: doc/BRIEF.md
# Dual-Channel Measurement Corruption Supervisor

This block supervises two redundant measurement channels that digitize the same physical quantity through separate digital filters. Each channel delivers samples with its own valid strobe. Once both channels have delivered a fresh sample, the two form a pair, and the supervisor evaluates that pair. A pair is a violation in two cases: the channels disagree by more than a tolerance, or either channel has jumped from its previous sample by more than a physically possible step. The jump check applies even when the two channels agree with each other.

When enough violations arrive in a row, the block treats the filter logic as upset and starts a recovery. The first recovery is a short filter reset. During the reset the output DAC code is frozen, so the converter keeps running. If another fault is declared within a window of pairs after that reset ends, the block escalates to a power cycle of the measurement card. During the power cycle the card power enable is dropped and the DAC code is forced to zero.

Every recovery is followed by a settling period during which no fault can be declared. A sticky status vector records which checks fired and which recovery actions were taken. The thresholds, the consecutive-violation count, the escalation window and the settling length are inputs. The reset and power-cycle durations are build-time clock counts.

Top module: `meas_sup_top`

## Requirements
- R1: While paired samples agree within `tol_i` and move by no more than `max_step_i`, `filt_rst_o` stays 0, `pwr_en_o` stays 1 and `dac_o` equals `dac_i`. A pair is formed once both channels have delivered a sample since the previous pair.
- R2: A pair with |A−B| > `tol_i` is a violation. A fault is declared only on the `consec_n_i`-th consecutive violating pair, and a clean pair restarts the count.
- R3: A pair in which either channel differs from that channel's previous paired sample by more than `max_step_i` is a violation, even when A and B agree. The first pair after reset or after a recovery has no previous sample and is not step-checked.
- R4: A fault declared outside the escalation window raises `filt_rst_o` for exactly `RST_CYC` cycles, starting on the clock edge that evaluates the faulting pair. Meanwhile `dac_o` holds the value `dac_i` had on that edge, and samples that arrive during the reset are discarded.
- R5: A fault declared while fewer than `esc_win_i` pairs have been evaluated since a filter reset ended drops `pwr_en_o` for exactly `PCYC_CYC` cycles instead, with `dac_o` = 0 throughout.
- R6: Once the escalation window has expired, and after any power cycle, the next fault again produces a filter reset and not a power cycle.
- R7: After any recovery, the first `blank_n_i` pairs are not counted as violations and cannot declare a fault.
- R8: `status_o` is sticky until reset and is 0 after reset. Bit 0 is a mismatch fault, bit 1 a step fault on channel A, bit 2 a step fault on channel B, bit 3 a filter reset taken, and bit 4 a power cycle taken. Bits 0–2 record the violation types of the pair that declared a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_vld_i | input | 1 | Channel A sample strobe |
| a_smp_i | input | SMP_W | Channel A sample, two's complement |
| b_vld_i | input | 1 | Channel B sample strobe |
| b_smp_i | input | SMP_W | Channel B sample, two's complement |
| tol_i | input | SMP_W | Largest allowed A/B disagreement |
| max_step_i | input | SMP_W | Largest allowed change between paired samples of one channel |
| consec_n_i | input | CNT_W | Consecutive violating pairs needed for a fault |
| esc_win_i | input | CNT_W | Pairs after a filter reset during which a fault escalates |
| blank_n_i | input | CNT_W | Settling pairs after a recovery |
| dac_i | input | DAC_W | DAC code from the regulation loop |
| filt_rst_o | output | 1 | Filter reset request |
| pwr_en_o | output | 1 | Measurement card power enable |
| dac_o | output | DAC_W | DAC code: passed through, held, or forced to zero |
| status_o | output | 5 | Sticky fault and action record |

## Verification
The assertions assume that the thresholds and counts stay constant while recovery and settling are in progress. They also assume that `dac_i` may change at any time without disturbing a held code. The bench sets the configuration once, right after reset. It changes `dac_i` on purpose during a filter reset, and it sends samples during recoveries to show that they are discarded. The random phase keeps the channel noise and the drift per pair well inside the tolerance and step limits, so any recovery that appears there is a design error rather than a stimulus artefact.

// File: rtl/meas_sup_pkg.sv
package meas_sup_pkg;
   typedef enum logic [1:0] {ST_MON, ST_BLANK, ST_FRST, ST_PCYC} sup_state_e;
   localparam int STAT_W     = 5;
   localparam int SB_MISM    = 0;
   localparam int SB_STEP_A  = 1;
   localparam int SB_STEP_B  = 2;
   localparam int SB_FRST    = 3;
   localparam int SB_PCYC    = 4;
endpackage

// File: rtl/meas_sup_chan.sv
module meas_sup_chan #(
   parameter int SMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush_i,
   input  logic             vld_i,
   input  logic [SMP_W-1:0] smp_i,
   input  logic             take_i,
   input  logic [SMP_W-1:0] max_step_i,
   output logic             fresh_o,
   output logic [SMP_W-1:0] cur_o,
   output logic             step_bad_o
);
   logic [SMP_W-1:0] cur_q, prev_q;
   logic             fresh_q, prev_ok_q;
   logic [SMP_W:0]   diff, mag;

   always_ff @(posedge clk) begin
      if (!rst_n || flush_i) begin
         cur_q     <= '0;
         prev_q    <= '0;
         fresh_q   <= 1'b0;
         prev_ok_q <= 1'b0;
      end else begin
         if (vld_i) begin
            cur_q   <= smp_i;
            fresh_q <= 1'b1;
         end else if (take_i) begin
            fresh_q <= 1'b0;
         end
         if (take_i) begin
            prev_q    <= cur_q;
            prev_ok_q <= 1'b1;
         end
      end
   end

   always_comb begin
      diff = {cur_q[SMP_W-1], cur_q} - {prev_q[SMP_W-1], prev_q};
      mag  = diff[SMP_W] ? (~diff + {{SMP_W{1'b0}}, 1'b1}) : diff;
   end

   assign step_bad_o = prev_ok_q && (mag > {1'b0, max_step_i});
   assign fresh_o    = fresh_q;
   assign cur_o      = cur_q;
endmodule

// File: rtl/meas_sup_seq.sv
module meas_sup_seq
   import meas_sup_pkg::*;
#(
   parameter int DAC_W    = 16,
   parameter int CNT_W    = 8,
   parameter int RST_CYC  = 100000,
   parameter int PCYC_CYC = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pair_i,
   input  logic              mism_i,
   input  logic              step_a_i,
   input  logic              step_b_i,
   input  logic [CNT_W-1:0]  consec_n_i,
   input  logic [CNT_W-1:0]  esc_win_i,
   input  logic [CNT_W-1:0]  blank_n_i,
   input  logic [DAC_W-1:0]  dac_i,
   output logic              filt_rst_o,
   output logic              pwr_en_o,
   output logic              flush_o,
   output logic [DAC_W-1:0]  dac_o,
   output logic [STAT_W-1:0] status_o
);
   localparam int TMR_MAX = (RST_CYC > PCYC_CYC) ? RST_CYC : PCYC_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);

   sup_state_e        state_q;
   logic [TMR_W-1:0]  tmr_q;
   logic [CNT_W-1:0]  consec_q, blank_q, esc_q;
   logic [DAC_W-1:0]  held_q;
   logic [STAT_W-1:0] stat_q;
   logic              viol, trip;
   logic [CNT_W:0]    consec_nxt;

   assign viol       = mism_i | step_a_i | step_b_i;
   assign consec_nxt = {1'b0, consec_q} + {{CNT_W{1'b0}}, 1'b1};
   assign trip       = consec_nxt >= {1'b0, consec_n_i};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_MON;
         tmr_q    <= '0;
         consec_q <= '0;
         blank_q  <= '0;
         esc_q    <= '0;
         held_q   <= '0;
         stat_q   <= '0;
      end else begin
         case (state_q)
            ST_MON: if (pair_i) begin
               if (esc_q != '0) esc_q <= esc_q - CNT_W'(1);
               if (!viol) begin
                  consec_q <= '0;
               end else if (!trip) begin
                  consec_q <= consec_nxt[CNT_W-1:0];
               end else begin
                  consec_q          <= '0;
                  stat_q[SB_MISM]   <= stat_q[SB_MISM]   | mism_i;
                  stat_q[SB_STEP_A] <= stat_q[SB_STEP_A] | step_a_i;
                  stat_q[SB_STEP_B] <= stat_q[SB_STEP_B] | step_b_i;
                  if (esc_q != '0) begin
                     state_q         <= ST_PCYC;
                     tmr_q           <= TMR_W'(PCYC_CYC - 1);
                     stat_q[SB_PCYC] <= 1'b1;
                     esc_q           <= '0;
                  end else begin
                     state_q         <= ST_FRST;
                     tmr_q           <= TMR_W'(RST_CYC - 1);
                     stat_q[SB_FRST] <= 1'b1;
                     held_q          <= dac_i;
                  end
               end
            end
            ST_BLANK: if (pair_i) begin
               if (esc_q != '0) esc_q <= esc_q - CNT_W'(1);
               blank_q <= blank_q - CNT_W'(1);
               if (blank_q == CNT_W'(1)) state_q <= ST_MON;
            end
            default: begin
               if (tmr_q == '0) begin
                  esc_q    <= (state_q == ST_FRST) ? esc_win_i : '0;
                  blank_q  <= blank_n_i;
                  consec_q <= '0;
                  state_q  <= (blank_n_i == '0) ? ST_MON : ST_BLANK;
               end else begin
                  tmr_q <= tmr_q - TMR_W'(1);
               end
            end
         endcase
      end
   end

   assign filt_rst_o = (state_q == ST_FRST);
   assign pwr_en_o   = (state_q != ST_PCYC);
   assign flush_o    = (state_q == ST_FRST) || (state_q == ST_PCYC);
   assign dac_o      = (state_q == ST_FRST) ? held_q :
                       (state_q == ST_PCYC) ? '0 : dac_i;
   assign status_o   = stat_q;
endmodule

// File: rtl/meas_sup_top.sv
module meas_sup_top
   import meas_sup_pkg::*;
#(
   parameter int SMP_W    = 16,
   parameter int DAC_W    = 16,
   parameter int CNT_W    = 8,
   parameter int RST_CYC  = 100000,
   parameter int PCYC_CYC = 100000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_vld_i,
   input  logic [SMP_W-1:0]  a_smp_i,
   input  logic              b_vld_i,
   input  logic [SMP_W-1:0]  b_smp_i,
   input  logic [SMP_W-1:0]  tol_i,
   input  logic [SMP_W-1:0]  max_step_i,
   input  logic [CNT_W-1:0]  consec_n_i,
   input  logic [CNT_W-1:0]  esc_win_i,
   input  logic [CNT_W-1:0]  blank_n_i,
   input  logic [DAC_W-1:0]  dac_i,
   output logic              filt_rst_o,
   output logic              pwr_en_o,
   output logic [DAC_W-1:0]  dac_o,
   output logic [4:0]        status_o
);
   localparam int NCH = 2;

   if (SMP_W < 2)     begin : g_bad_smp   $error("SMP_W must be at least 2");   end
   if (DAC_W < 1)     begin : g_bad_dac   $error("DAC_W must be at least 1");   end
   if (CNT_W < 1)     begin : g_bad_cnt   $error("CNT_W must be at least 1");   end
   if (RST_CYC < 1)   begin : g_bad_rst   $error("RST_CYC must be positive");   end
   if (PCYC_CYC < 1)  begin : g_bad_pcyc  $error("PCYC_CYC must be positive");  end

   logic [NCH-1:0]   vld, fresh, step_bad;
   logic [SMP_W-1:0] smp [NCH];
   logic [SMP_W-1:0] cur [NCH];
   logic             pair, flush, mism;
   logic [SMP_W:0]   ab_diff, ab_mag;

   assign vld    = {b_vld_i, a_vld_i};
   assign smp[0] = a_smp_i;
   assign smp[1] = b_smp_i;
   assign pair   = &fresh;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      meas_sup_chan #(.SMP_W(SMP_W)) chan_i (
         .clk        (clk),
         .rst_n      (rst_n),
         .flush_i    (flush),
         .vld_i      (vld[c]),
         .smp_i      (smp[c]),
         .take_i     (pair),
         .max_step_i (max_step_i),
         .fresh_o    (fresh[c]),
         .cur_o      (cur[c]),
         .step_bad_o (step_bad[c])
      );
   end

   always_comb begin
      ab_diff = {cur[0][SMP_W-1], cur[0]} - {cur[1][SMP_W-1], cur[1]};
      ab_mag  = ab_diff[SMP_W] ? (~ab_diff + {{SMP_W{1'b0}}, 1'b1}) : ab_diff;
   end
   assign mism = ab_mag > {1'b0, tol_i};

   meas_sup_seq #(
      .DAC_W    (DAC_W),
      .CNT_W    (CNT_W),
      .RST_CYC  (RST_CYC),
      .PCYC_CYC (PCYC_CYC)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .pair_i     (pair),
      .mism_i     (mism),
      .step_a_i   (step_bad[0]),
      .step_b_i   (step_bad[1]),
      .consec_n_i (consec_n_i),
      .esc_win_i  (esc_win_i),
      .blank_n_i  (blank_n_i),
      .dac_i      (dac_i),
      .filt_rst_o (filt_rst_o),
      .pwr_en_o   (pwr_en_o),
      .flush_o    (flush),
      .dac_o      (dac_o),
      .status_o   (status_o)
   );
endmodule

// File: rtl/meas_sup_chk.sv
module meas_sup_chk #(
   parameter int DAC_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             filt_rst_o,
   input logic             pwr_en_o,
   input logic [DAC_W-1:0] dac_o,
   input logic [4:0]       status_o
);
   // R4 / R5: the two recovery actions never overlap
   assert_one_action_R5: assert property (@(posedge clk) disable iff (!rst_n)
      filt_rst_o |-> pwr_en_o);

   // R5: DAC forced to zero while the card is unpowered
   assert_dac_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en_o |-> (dac_o == '0));

   // R4: DAC code frozen through a filter reset
   assert_dac_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (filt_rst_o && $past(filt_rst_o)) |-> $stable(dac_o));

   // R8: status bits never clear once set
   assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_o & $past(status_o)) == $past(status_o)));

   // R8: filter reset recorded when it starts
   assert_frst_logged_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(filt_rst_o) |-> status_o[3]);

   // R8: power cycle recorded when it starts
   assert_pcyc_logged_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_en_o) |-> status_o[4]);
endmodule

bind meas_sup_top meas_sup_chk #(.DAC_W(DAC_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .filt_rst_o (filt_rst_o),
   .pwr_en_o   (pwr_en_o),
   .dac_o      (dac_o),
   .status_o   (status_o)
);

// File: tb/meas_sup_tb.sv
module meas_sup_top_tb_top;
   localparam int SMP_W = 12, DAC_W = 12, CNT_W = 8, RST_CYC = 20, PCYC_CYC = 30;
   localparam int TOL = 20, STEP = 50, CONSEC = 3, ESCW = 6, BLANK = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic a_vld = 1'b0, b_vld = 1'b0;
   logic [SMP_W-1:0] a_smp = '0, b_smp = '0;
   logic [DAC_W-1:0] dac_in = '0;
   logic filt_rst, pwr_en;
   logic [DAC_W-1:0] dac_out;
   logic [4:0] status;
   int checks = 0, fails = 0;

   always #5ns clk = ~clk;

   meas_sup_top #(.SMP_W(SMP_W), .DAC_W(DAC_W), .CNT_W(CNT_W),
                  .RST_CYC(RST_CYC), .PCYC_CYC(PCYC_CYC)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_vld_i(a_vld), .a_smp_i(a_smp), .b_vld_i(b_vld), .b_smp_i(b_smp),
      .tol_i(SMP_W'(TOL)), .max_step_i(SMP_W'(STEP)),
      .consec_n_i(CNT_W'(CONSEC)), .esc_win_i(CNT_W'(ESCW)), .blank_n_i(CNT_W'(BLANK)),
      .dac_i(dac_in), .filt_rst_o(filt_rst), .pwr_en_o(pwr_en),
      .dac_o(dac_out), .status_o(status));

   function automatic int absdiff(input int x, input int y);
      return (x > y) ? x - y : y - x;
   endfunction

   function automatic bit pair_clean(input int a, input int b, input int pa, input int pb);
      return absdiff(a, b) <= TOL && absdiff(a, pa) <= STEP && absdiff(b, pb) <= STEP;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_pair(input int a, input int b);
      @(negedge clk);
      a_vld = 1'b1; b_vld = 1'b1;
      a_smp = SMP_W'(a); b_smp = SMP_W'(b);
      @(negedge clk);
      a_vld = 1'b0; b_vld = 1'b0;
      @(negedge clk);
   endtask

   task automatic chk_idle(input string req);
      chk(filt_rst == 1'b0, req, int'(filt_rst), 0);
      chk(pwr_en == 1'b1, req, int'(pwr_en), 1);
      chk(dac_out == dac_in, req, int'(dac_out), int'(dac_in));
   endtask

   task automatic len_high_frst(output int n);
      n = 0;
      while (filt_rst && n < 1000) begin n++; @(negedge clk); end
   endtask

   task automatic len_low_pwr(output int n);
      n = 0;
      while (!pwr_en && n < 1000) begin
         if (dac_out != '0) chk(1'b0, "R5 dac off", int'(dac_out), 0);
         n++; @(negedge clk);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int n, base, a, b, pa, pb;
      void'($urandom(32'd2718));
      dac_in = 12'h0AB;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state, R8
      chk(status == 5'b0, "R8 reset status", int'(status), 0);
      chk_idle("R1 reset outputs");

      // R2: two violating pairs then a clean one, twice: no fault
      for (int k = 0; k < 2; k++) begin
         send_pair(100, 130); chk_idle("R2 one violation");
         send_pair(100, 130); chk_idle("R2 two violations");
         send_pair(100, 110); chk_idle("R2 clean restarts count");
      end

      // R3: agreeing channels that jump implausibly
      send_pair(100, 100); chk_idle("R3 clean lead-in");
      dac_in = 12'h123;
      send_pair(400, 400); chk_idle("R3 step 1");
      send_pair(100, 100); chk_idle("R3 step 2");
      send_pair(400, 400);
      chk(filt_rst == 1'b1, "R3 step fault reset", int'(filt_rst), 1);
      chk(status == 5'b01110, "R8 step fault status", int'(status), 5'b01110);
      // R4: DAC hold during filter reset, samples discarded
      dac_in = 12'h456;
      @(negedge clk);
      chk(dac_out == 12'h123, "R4 dac held", int'(dac_out), 12'h123);
      a_vld = 1'b1; b_vld = 1'b1; a_smp = 12'd999; b_smp = 12'd0;
      @(negedge clk);
      a_vld = 1'b0; b_vld = 1'b0;
      len_high_frst(n);
      chk(n == RST_CYC - 2, "R4 reset length", n + 2, RST_CYC);
      chk_idle("R4 after reset");

      // R7: two violating pairs inside settling period are ignored
      send_pair(100, 200); chk_idle("R7 blank pair 1");
      send_pair(100, 200); chk_idle("R7 blank pair 2");
      chk(status == 5'b01110, "R7 status unchanged", int'(status), 5'b01110);

      // R5: fault inside escalation window -> power cycle
      send_pair(100, 200); chk_idle("R5 violation 1");
      send_pair(100, 200); chk_idle("R5 violation 2");
      send_pair(100, 200);
      chk(pwr_en == 1'b0, "R5 power cycle", int'(pwr_en), 0);
      chk(filt_rst == 1'b0, "R5 no filter reset", int'(filt_rst), 0);
      chk(status == 5'b11111, "R8 full status", int'(status), 5'b11111);
      len_low_pwr(n);
      chk(n == PCYC_CYC, "R5 power-off length", n, PCYC_CYC);
      chk_idle("R5 after power cycle");

      // R6: after power cycle the next fault is a filter reset
      for (int k = 0; k < 2; k++) begin send_pair(300, 300); chk_idle("R7 blank clean"); end
      send_pair(300, 340); chk_idle("R6 violation 1");
      send_pair(300, 340); chk_idle("R6 violation 2");
      send_pair(300, 340);
      chk(filt_rst == 1'b1 && pwr_en == 1'b1, "R6 reset after power cycle", int'(filt_rst), 1);
      len_high_frst(n);
      chk(n == RST_CYC, "R4 reset length again", n, RST_CYC);

      // R6: window expiry after a filter reset
      for (int k = 0; k < 7; k++) begin send_pair(300, 300); chk_idle("R6 window drains"); end
      send_pair(300, 340); send_pair(300, 340); send_pair(300, 340);
      chk(filt_rst == 1'b1, "R6 expired window gives reset", int'(filt_rst), 1);
      chk(pwr_en == 1'b1, "R6 no power cycle", int'(pwr_en), 1);
      len_high_frst(n);

      // R1: random agreeing, plausible stream
      base = 300; pa = 300; pb = 300;
      for (int k = 0; k < 40; k++) begin
         base = base + $urandom_range(60) - 30;
         if (base < 100) base = 100;
         if (base > 1900) base = 1900;
         a = base + $urandom_range(8);
         b = base + $urandom_range(8);
         dac_in = DAC_W'($urandom);
         if (pair_clean(a, b, pa, pb)) begin
            send_pair(a, b);
            chk_idle("R1 random clean pair");
            pa = a; pb = b;
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule